// File: doc/BRIEF.md
# Floating-Point Trap Controller

This block sits next to a floating-point arithmetic unit and makes the trap decision for each floating-point instruction. When an instruction is accepted, the block looks at the unit-enable bit from the status word, at a flag for an unimplemented opcode, and at the raw status the arithmetic unit reports. It then records at most one cause bit, decides whether the result may be written back and whether a quiet NaN replaces it, and raises a trap with one of three vector codes.

When a trap is raised, the block runs the exception entry on its own. It writes the program counter as a word below the stack pointer, then the status word as a half-word below that. In the last step it lowers the stack pointer by eight, clears the interrupt-enable bit and loads the handler address into the program counter. While this runs, a busy output blocks new floating-point issue. The decision outputs appear one cycle after the accepted issue. The entry writes follow in the cycles after that, one per cycle.

Top module: `fpu_trap_ctrl`

## Requirements
- R1: After reset, trap_o, wb_en_o, wb_qnan_o, mem_we_o, sp_we_o, pc_we_o, ie_clr_o and busy_o are 0, and cause_o is 0.
- R2: An accepted issue with fpu_en_i low gives a one-cycle trap_o with trap_code_o = 0x1c0 in the next cycle, with no write-back and cause_o = 0. This holds even when unimp_i is also high.
- R3: An accepted issue with fpu_en_i high and unimp_i high gives trap_code_o = 0x1c8, no write-back and cause_o = 0.
- R4: The cause field uses bit 4 = invalid (V), bit 3 = divide-by-zero (Z), bit 2 = overflow (O), bit 1 = underflow (U) and bit 0 = inexact (I). trap_en_i uses the same positions. Every accepted issue replaces the previous cause field, so an operation with no cause leaves cause_o = 0.
- R5: st_invalid_i with trap_en_i[4] set records V and writes nothing. With trap_en_i[4] clear, no cause is recorded and a write-back occurs with wb_qnan_o = 1. Invalid takes precedence over every other status bit.
- R6: st_divzero_i with trap_en_i[3] set records Z and writes nothing. With trap_en_i[3] clear, the remaining status is mapped as in R7.
- R7: The rest of the status gives at most one cause, taking the first match in this order: overflow with the O enable, then underflow or denormal with the U enable, then inexact or rounded with the I enable. A condition whose enable is clear records nothing.
- R8: wb_en_o rises in the cycle after an accepted, enabled, implemented issue exactly when no cause was recorded. A recorded cause gives trap_code_o = 0x1d0.
- R9: A trap starts the entry sequence. In the cycle of trap_o, the block writes the captured PC as a word at SP-4. In the next cycle it writes the captured PSW, zero-extended, as a half-word at SP-8. In the cycle after that it pulses sp_we_o with SP-8, ie_clr_o, and pc_we_o with pc_o = 0x40000008.
- R10: busy_o is high from the trap_o cycle through the PC-load cycle, and low in the cycle after it. An issue while busy_o is high is ignored: it raises no trap, causes no write-back and leaves cause_o unchanged.
- R11: trap_o lasts one cycle per accepted trapping issue. A non-trapping issue leaves busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | A floating-point instruction completes this cycle |
| fpu_en_i | input | 1 | FPU-enable bit of the status word |
| unimp_i | input | 1 | Opcode is an unimplemented floating-point instruction |
| st_invalid_i | input | 1 | Invalid-operand condition |
| st_divzero_i | input | 1 | Finite number divided by zero |
| st_ovf_i | input | 1 | Overflow status |
| st_unf_i | input | 1 | Underflow status |
| st_denorm_i | input | 1 | Denormal status |
| st_inexact_i | input | 1 | Inexact status |
| st_rounded_i | input | 1 | Rounded status |
| trap_en_i | input | 5 | Enables, same bit positions as the cause field |
| pc_i | input | 32 | Current program counter |
| psw_i | input | 16 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| cause_o | output | 5 | Recorded cause field |
| wb_en_o | output | 1 | Result write-back permitted |
| wb_qnan_o | output | 1 | Write a quiet NaN instead of the computed result |
| trap_o | output | 1 | Trap request pulse |
| trap_code_o | output | 12 | Trap vector code |
| busy_o | output | 1 | Entry sequence running, issue blocked |
| mem_we_o | output | 1 | Stack write strobe |
| mem_word_o | output | 1 | 1 = word write, 0 = half-word write |
| mem_addr_o | output | 32 | Stack write address |
| mem_data_o | output | 32 | Stack write data |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 32 | New stack pointer |
| ie_clr_o | output | 1 | Clear interrupt-enable bit |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 32 | Handler address |

## Verification
The bench targets the priority corners. These are disabled together with unimplemented, invalid together with every other status bit, and overflow, underflow and inexact raised at once under several enable masks. A design that got one of these wrong would report 0x1c8 where 0x1c0 belongs, or record the lower-priority cause, or record two bits. Masked conditions are checked to still write back, since a design that traps on a status bit with its enable clear would lose results. The bench also checks the stack addresses, the access width of each push and the order of the pushes. It issues an instruction while the entry sequence is running and observes that no second trap fires and that the cause field is unchanged.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int CAUSE_W = 5;
    localparam int CODE_W  = 12;

    // cause / enable bit positions
    localparam int C_V = 4;
    localparam int C_Z = 3;
    localparam int C_O = 2;
    localparam int C_U = 1;
    localparam int C_I = 0;

    localparam logic [CODE_W-1:0] CODE_OFF   = 12'h1c0;
    localparam logic [CODE_W-1:0] CODE_UNIMP = 12'h1c8;
    localparam logic [CODE_W-1:0] CODE_SIG   = 12'h1d0;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PUSH_PC,
        SEQ_PUSH_PSW,
        SEQ_FINISH
    } seq_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               wb;
        logic               qnan;
        logic               trap;
        logic [CODE_W-1:0]  code;
    } verdict_t;
endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
    import fpx_pkg::*;
(
    input  logic               fpu_en,
    input  logic               unimp,
    input  logic               st_invalid,
    input  logic               st_divzero,
    input  logic               st_ovf,
    input  logic               st_unf,
    input  logic               st_denorm,
    input  logic               st_inexact,
    input  logic               st_rounded,
    input  logic [CAUSE_W-1:0] enable,
    output verdict_t           verdict
);
    always_comb begin
        verdict       = '0;
        if (!fpu_en) begin
            verdict.trap = 1'b1;
            verdict.code = CODE_OFF;
        end else if (unimp) begin
            verdict.trap = 1'b1;
            verdict.code = CODE_UNIMP;
        end else begin
            if (st_invalid) begin
                if (enable[C_V]) verdict.cause[C_V] = 1'b1;
                else             verdict.qnan       = 1'b1;
            end else if (st_divzero && enable[C_Z]) begin
                verdict.cause[C_Z] = 1'b1;
            end else if (st_ovf && enable[C_O]) begin
                verdict.cause[C_O] = 1'b1;
            end else if ((st_unf || st_denorm) && enable[C_U]) begin
                verdict.cause[C_U] = 1'b1;
            end else if ((st_inexact || st_rounded) && enable[C_I]) begin
                verdict.cause[C_I] = 1'b1;
            end
            verdict.wb   = (verdict.cause == '0);
            verdict.trap = !verdict.wb;
            verdict.code = verdict.wb ? '0 : CODE_SIG;
        end
    end
endmodule

// File: rtl/fpx_entry_seq.sv
module fpx_entry_seq
    import fpx_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PSW_W      = 16,
    parameter logic [31:0] HANDLER_PC = 32'h4000_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [PSW_W-1:0]  psw_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_data,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_new,
    output logic              ie_clr,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_new
);
    localparam logic [ADDR_W-1:0] PC_SLOT  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] PSW_SLOT = ADDR_W'(8);

    typedef struct packed {
        seq_e              st;
        logic [ADDR_W-1:0] pc;
        logic [PSW_W-1:0]  psw;
        logic [ADDR_W-1:0] sp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: if (start) begin
                s_d.st  = SEQ_PUSH_PC;
                s_d.pc  = pc_in;
                s_d.psw = psw_in;
                s_d.sp  = sp_in;
            end
            SEQ_PUSH_PC:  s_d.st = SEQ_PUSH_PSW;
            SEQ_PUSH_PSW: s_d.st = SEQ_FINISH;
            default:      s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        busy     = (s_q.st != SEQ_IDLE);
        mem_we   = (s_q.st == SEQ_PUSH_PC) || (s_q.st == SEQ_PUSH_PSW);
        mem_word = (s_q.st == SEQ_PUSH_PC);
        mem_addr = '0;
        mem_data = '0;
        if (s_q.st == SEQ_PUSH_PC) begin
            mem_addr = s_q.sp - PC_SLOT;
            mem_data = s_q.pc;
        end else if (s_q.st == SEQ_PUSH_PSW) begin
            mem_addr = s_q.sp - PSW_SLOT;
            mem_data = ADDR_W'(s_q.psw);
        end
        sp_we  = (s_q.st == SEQ_FINISH);
        sp_new = sp_we ? (s_q.sp - PSW_SLOT) : '0;
        ie_clr = sp_we;
        pc_we  = sp_we;
        pc_new = sp_we ? ADDR_W'(HANDLER_PC) : '0;
    end
endmodule

// File: rtl/fpu_trap_ctrl.sv
module fpu_trap_ctrl
    import fpx_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PSW_W      = 16,
    parameter logic [31:0] HANDLER_PC = 32'h4000_0008
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic               fpu_en_i,
    input  logic               unimp_i,
    input  logic               st_invalid_i,
    input  logic               st_divzero_i,
    input  logic               st_ovf_i,
    input  logic               st_unf_i,
    input  logic               st_denorm_i,
    input  logic               st_inexact_i,
    input  logic               st_rounded_i,
    input  logic [CAUSE_W-1:0] trap_en_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [PSW_W-1:0]   psw_i,
    input  logic [ADDR_W-1:0]  sp_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               wb_en_o,
    output logic               wb_qnan_o,
    output logic               trap_o,
    output logic [CODE_W-1:0]  trap_code_o,
    output logic               busy_o,
    output logic               mem_we_o,
    output logic               mem_word_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [ADDR_W-1:0]  mem_data_o,
    output logic               sp_we_o,
    output logic [ADDR_W-1:0]  sp_o,
    output logic               ie_clr_o,
    output logic               pc_we_o,
    output logic [ADDR_W-1:0]  pc_o
);
    verdict_t vd;
    verdict_t r_d, r_q;
    logic     accept;

    fpx_cause_map u_map (
        .fpu_en     (fpu_en_i),
        .unimp      (unimp_i),
        .st_invalid (st_invalid_i),
        .st_divzero (st_divzero_i),
        .st_ovf     (st_ovf_i),
        .st_unf     (st_unf_i),
        .st_denorm  (st_denorm_i),
        .st_inexact (st_inexact_i),
        .st_rounded (st_rounded_i),
        .enable     (trap_en_i),
        .verdict    (vd)
    );

    assign accept = issue_i && !busy_o;

    always_comb begin
        r_d      = r_q;
        r_d.wb   = 1'b0;
        r_d.qnan = 1'b0;
        r_d.trap = 1'b0;
        if (accept) r_d = vd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cause_o     = r_q.cause;
    assign wb_en_o     = r_q.wb;
    assign wb_qnan_o   = r_q.qnan;
    assign trap_o      = r_q.trap;
    assign trap_code_o = r_q.code;

    fpx_entry_seq #(
        .ADDR_W     (ADDR_W),
        .PSW_W      (PSW_W),
        .HANDLER_PC (HANDLER_PC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && vd.trap),
        .pc_in    (pc_i),
        .psw_in   (psw_i),
        .sp_in    (sp_i),
        .busy     (busy_o),
        .mem_we   (mem_we_o),
        .mem_word (mem_word_o),
        .mem_addr (mem_addr_o),
        .mem_data (mem_data_o),
        .sp_we    (sp_we_o),
        .sp_new   (sp_o),
        .ie_clr   (ie_clr_o),
        .pc_we    (pc_we_o),
        .pc_new   (pc_o)
    );
endmodule

// File: rtl/fpx_trap_chk.sv
module fpx_trap_chk
    import fpx_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] HANDLER_PC = 32'h4000_0008
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_i,
    input logic               fpu_en_i,
    input logic               unimp_i,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               wb_en_o,
    input logic               trap_o,
    input logic [CODE_W-1:0]  trap_code_o,
    input logic               busy_o,
    input logic               mem_we_o,
    input logic               mem_word_o,
    input logic               pc_we_o,
    input logic               sp_we_o,
    input logic               ie_clr_o,
    input logic [ADDR_W-1:0]  pc_o
);
    AST_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !busy_o && !fpu_en_i |=> trap_o && trap_code_o == CODE_OFF); // R2
    AST_UNIMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !busy_o && fpu_en_i && unimp_i |=> trap_o && trap_code_o == CODE_UNIMP); // R3
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_o) <= 1); // R7
    AST_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> cause_o == '0 && !trap_o); // R8
    AST_SIG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o && trap_code_o == CODE_SIG |-> cause_o != '0); // R8
    AST_PUSH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> mem_we_o && mem_word_o); // R9
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && mem_word_o |=> mem_we_o && !mem_word_o); // R9
    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && !mem_word_o |=> pc_we_o && sp_we_o && ie_clr_o && pc_o == ADDR_W'(HANDLER_PC)); // R9
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |=> !busy_o); // R10
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o); // R11
endmodule

bind fpu_trap_ctrl fpx_trap_chk #(.ADDR_W(ADDR_W), .HANDLER_PC(HANDLER_PC)) u_chk (.*);

// File: tb/fpu_trap_ctrl_tb.sv
module fpu_trap_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0, fpu_en_i = 1'b1, unimp_i = 1'b0;
    logic        st_invalid_i = 1'b0, st_divzero_i = 1'b0, st_ovf_i = 1'b0;
    logic        st_unf_i = 1'b0, st_denorm_i = 1'b0, st_inexact_i = 1'b0, st_rounded_i = 1'b0;
    logic [4:0]  trap_en_i = 5'b0;
    logic [31:0] pc_i = 32'h0, sp_i = 32'h0;
    logic [15:0] psw_i = 16'h0;
    logic [4:0]  cause_o;
    logic        wb_en_o, wb_qnan_o, trap_o, busy_o;
    logic [11:0] trap_code_o;
    logic        mem_we_o, mem_word_o, sp_we_o, ie_clr_o, pc_we_o;
    logic [31:0] mem_addr_o, mem_data_o, sp_o, pc_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fpu_trap_ctrl u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one instruction; returns at the negedge after the accepting edge
    task automatic issue(input logic en, input logic un, input logic [6:0] st, input logic [4:0] ten);
        @(negedge clk);
        fpu_en_i = en; unimp_i = un; trap_en_i = ten;
        {st_invalid_i, st_divzero_i, st_ovf_i, st_unf_i, st_denorm_i, st_inexact_i, st_rounded_i} = st;
        issue_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        st_invalid_i = 0; st_divzero_i = 0; st_ovf_i = 0; st_unf_i = 0;
        st_denorm_i = 0; st_inexact_i = 0; st_rounded_i = 0;
    endtask

    // status vector order: invalid, divzero, ovf, unf, denorm, inexact, rounded
    task automatic expect_wb(input string req, input logic qnan);
        chk(req, {trap_o, wb_en_o, wb_qnan_o, cause_o, busy_o}, {1'b0, 1'b1, qnan, 5'b0, 1'b0});
    endtask

    task automatic expect_trap(input string req, input logic [11:0] code, input logic [4:0] cause);
        chk(req, {trap_o, wb_en_o, trap_code_o, cause_o}, {1'b1, 1'b0, code, cause});
    endtask

    task automatic finish_seq;
        @(negedge clk); @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", {trap_o, wb_en_o, wb_qnan_o, mem_we_o, sp_we_o, pc_we_o, ie_clr_o, busy_o, cause_o}, '0);
    endtask

    task automatic t_disabled;
        issue(1'b0, 1'b1, 7'b0, 5'b11111);
        expect_trap("R2 off beats unimp", 12'h1c0, 5'b0);
        finish_seq();
    endtask

    task automatic t_unimp;
        issue(1'b1, 1'b1, 7'b0010000, 5'b11111);
        expect_trap("R3", 12'h1c8, 5'b0);
        finish_seq();
    endtask

    task automatic t_invalid;
        issue(1'b1, 1'b0, 7'b1111111, 5'b11111);
        expect_trap("R5 V priority", 12'h1d0, 5'b10000);
        finish_seq();
        issue(1'b1, 1'b0, 7'b1000000, 5'b01111);
        expect_wb("R5 qnan", 1'b1);
    endtask

    task automatic t_divzero;
        issue(1'b1, 1'b0, 7'b0110000, 5'b01100);
        expect_trap("R6 Z", 12'h1d0, 5'b01000);
        finish_seq();
        issue(1'b1, 1'b0, 7'b0100000, 5'b10111);
        expect_wb("R6 masked", 1'b0);
        issue(1'b1, 1'b0, 7'b0110000, 5'b00100);
        expect_trap("R6 masked falls to O", 12'h1d0, 5'b00100);
        finish_seq();
    endtask

    task automatic t_priority;
        issue(1'b1, 1'b0, 7'b0011111, 5'b00111);
        expect_trap("R7 O first", 12'h1d0, 5'b00100);
        finish_seq();
        issue(1'b1, 1'b0, 7'b0011111, 5'b00011);
        expect_trap("R7 U when O masked", 12'h1d0, 5'b00010);
        finish_seq();
        issue(1'b1, 1'b0, 7'b0000100, 5'b00010);
        expect_trap("R7 denorm gives U", 12'h1d0, 5'b00010);
        finish_seq();
        issue(1'b1, 1'b0, 7'b0000001, 5'b00001);
        expect_trap("R7 rounded gives I", 12'h1d0, 5'b00001);
        finish_seq();
        issue(1'b1, 1'b0, 7'b0011111, 5'b11000);
        expect_wb("R7 all masked", 1'b0);
        issue(1'b1, 1'b0, 7'b0000000, 5'b11111);
        expect_wb("R4 R8 clean op clears cause", 1'b0);
    endtask

    task automatic t_sequence;
        pc_i = 32'h1234_5678; psw_i = 16'hbeef; sp_i = 32'h0000_1000;
        issue(1'b1, 1'b0, 7'b0000010, 5'b00001);
        pc_i = 32'h0; psw_i = 16'h0; sp_i = 32'h0;
        chk("R9 push pc", {trap_o, busy_o, mem_we_o, mem_word_o, mem_addr_o, mem_data_o},
            {1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0ffc, 32'h1234_5678});
        // issue while busy: must be ignored
        @(negedge clk);
        fpu_en_i = 1'b0; issue_i = 1'b1;
        chk("R9 push psw", {trap_o, busy_o, mem_we_o, mem_word_o, mem_addr_o, mem_data_o},
            {1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0ff8, 32'h0000_beef});
        @(negedge clk);
        issue_i = 1'b0; fpu_en_i = 1'b1;
        chk("R9 finish", {mem_we_o, sp_we_o, sp_o, ie_clr_o, pc_we_o, pc_o, busy_o},
            {1'b0, 1'b1, 32'h0000_0ff8, 1'b1, 1'b1, 32'h4000_0008, 1'b1});
        chk("R10 ignored issue", {trap_o, wb_en_o, cause_o}, {1'b0, 1'b0, 5'b00001});
        @(negedge clk);
        chk("R10 idle", {busy_o, trap_o, pc_we_o, mem_we_o, cause_o}, {1'b0, 1'b0, 1'b0, 1'b0, 5'b00001});
        @(negedge clk);
        chk("R11 no second trap", {busy_o, trap_o}, 2'b00);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_unimp();
        t_invalid();
        t_divzero();
        t_priority();
        t_sequence();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule